// File: doc/BRIEF.md
# I2S Sample Byte Packer

This block moves audio samples between two byte-wide FIFOs and a codec port that works in whole samples. When the codec raises a request strobe, it also gives a count of samples to send and a count of samples to capture. The block then pops transmit bytes and packs them into samples, least-significant byte first. After that it takes each received sample from the codec, splits it into bytes, least-significant first, and pushes them into the receive FIFO. One byte moves per clock cycle.

The sample width is set in whole bytes through a 7-bit width field that holds the width in bits minus one. The block starts a request only when the I2S frame format is selected and the global enable is set. The transmit and receive halves each have their own enables. If the transmit FIFO runs dry while requested bytes remain, the block raises a sticky underrun flag. If the receive FIFO is full while bytes remain, it raises a sticky overrun flag. Busy stays high for the whole request.

Top module: `i2s_sample_packer`

## Requirements
- R1: A request is accepted only on `req` high while idle, with `cfg_fmt` equal to 3 (I2S) and `cfg_enable` high. Any other request has no effect: no pops, no pushes, no samples, and no change to busy or the flags.
- R2: Bytes per sample equal (`cfg_width_m1` + 1) / 8, rounded down and capped at SMP_W/8. A width field of 15 gives 2 bytes, 23 gives 3, 31 gives 4, and 127 is capped at 4.
- R3: A transmit sample is built from popped bytes. The first byte goes to bits 7:0, the next to bits 15:8, and so on. Each completed sample appears on `smp_out` with a one-cycle `smp_out_vld` pulse.
- R4: Transmit bytes are popped only when `cfg_tx_en` and `cfg_tx_drive` are both high for the request. Otherwise the transmit count is ignored and no underrun can be raised.
- R5: If the transmit FIFO is empty while requested bytes remain, `tx_underrun` is set and the transmit half ends. A partly built sample is still sent with its missing upper bytes zero. A request that exactly drains the FIFO does not set the flag.
- R6: When `cfg_rx_en` is high, each received sample is taken once (`smp_in_take` high with its first byte) and pushed into the receive FIFO, least-significant byte first, one byte per cycle.
- R7: If the receive FIFO is full while requested bytes remain, `rx_overrun` is set and the request ends. No byte is pushed into a full FIFO. A request that fills the FIFO exactly does not set the flag.
- R8: `busy` stays high from the cycle after acceptance until the request ends. A fault-free request lasts Ntx + Nrx + 2 cycles, where N is the byte count of each half. `req` is ignored while busy.
- R9: Both flags are sticky. They clear only when the next request is accepted.
- R10: After reset, `busy`, `tx_underrun`, `rx_overrun`, `smp_out_vld`, `txf_pop` and `rxf_push` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 3 | Frame format select; 3 selects I2S |
| cfg_width_m1 | input | 7 | Sample width in bits minus one |
| cfg_enable | input | 1 | Global enable |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_tx_drive | input | 1 | Transmit data output enable |
| cfg_rx_en | input | 1 | Receive enable |
| req | input | 1 | Codec request strobe |
| req_tx_cnt | input | CNT_W | Transmit samples requested |
| req_rx_cnt | input | CNT_W | Receive samples requested |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_data | output | 8 | Byte pushed into the receive FIFO |
| smp_out | output | SMP_W | Packed transmit sample |
| smp_out_vld | output | 1 | Transmit sample valid pulse |
| smp_in | input | SMP_W | Received sample from the codec |
| smp_in_take | output | 1 | Received sample consumed |
| busy | output | 1 | Request in progress |
| tx_underrun | output | 1 | Sticky transmit underrun |
| rx_overrun | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with its defaults: 32-bit samples and 8-bit request counts. That allows 1 to 4 bytes per sample, so the width field is driven at 7, 15, 23, 31 and 127. These values cover every byte count and the cap. The bench sets its modelled receive FIFO capacity per test, which makes it possible to hit the exact-fill and one-short cases. Underrun is reached mid-sample by using an odd byte count with 16-bit samples.

// File: rtl/i2s_sample_packer.sv
`timescale 1ns/1ps
module i2s_sample_packer #(
  parameter int SMP_W   = 32,
  parameter int CNT_W   = 8,
  parameter int FMT_SEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_fmt,
  input  logic [6:0]       cfg_width_m1,
  input  logic             cfg_enable,
  input  logic             cfg_tx_en,
  input  logic             cfg_tx_drive,
  input  logic             cfg_rx_en,
  input  logic             req,
  input  logic [CNT_W-1:0] req_tx_cnt,
  input  logic [CNT_W-1:0] req_rx_cnt,
  input  logic             txf_empty,
  input  logic [7:0]       txf_data,
  output logic             txf_pop,
  input  logic             rxf_full,
  output logic             rxf_push,
  output logic [7:0]       rxf_data,
  output logic [SMP_W-1:0] smp_out,
  output logic             smp_out_vld,
  input  logic [SMP_W-1:0] smp_in,
  output logic             smp_in_take,
  output logic             busy,
  output logic             tx_underrun,
  output logic             rx_overrun
);
  localparam int MAXB   = SMP_W / 8;
  localparam int BW     = $clog2(MAXB + 1);
  localparam int LEFT_W = CNT_W + BW;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t               st;
  logic [BW-1:0]     bps_q, bidx;
  logic [LEFT_W-1:0] tx_left, rx_left;
  logic [SMP_W-1:0]  acc, shr, placed;
  logic [7:0]        wbits;
  logic [4:0]        raw_b;
  logic [BW-1:0]     bps;
  logic              go, tx_last;

  assign wbits   = {1'b0, cfg_width_m1} + 8'd1;
  assign raw_b   = wbits[7:3];
  assign bps     = (raw_b > 5'(MAXB)) ? BW'(MAXB) : BW'(raw_b);
  assign go      = req && (cfg_fmt == 3'(FMT_SEL)) && cfg_enable;

  assign busy        = (st != S_IDLE);
  assign txf_pop     = (st == S_TX) && (tx_left != '0) && !txf_empty;
  assign rxf_push    = (st == S_RX) && (rx_left != '0) && !rxf_full;
  assign smp_in_take = rxf_push && (bidx == '0);
  assign rxf_data    = (bidx == '0) ? smp_in[7:0] : shr[7:0];
  assign tx_last     = (bidx == bps_q - 1'b1) || (tx_left == LEFT_W'(1));
  assign placed      = acc | (SMP_W'(txf_data) << {bidx, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bps_q       <= '0;
      bidx        <= '0;
      tx_left     <= '0;
      rx_left     <= '0;
      acc         <= '0;
      shr         <= '0;
      smp_out     <= '0;
      smp_out_vld <= 1'b0;
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      smp_out_vld <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st          <= S_TX;
          bps_q       <= bps;
          bidx        <= '0;
          acc         <= '0;
          tx_left     <= (cfg_tx_en && cfg_tx_drive) ?
                         LEFT_W'(req_tx_cnt) * LEFT_W'(bps) : '0;
          rx_left     <= cfg_rx_en ? LEFT_W'(req_rx_cnt) * LEFT_W'(bps) : '0;
          tx_underrun <= 1'b0;
          rx_overrun  <= 1'b0;
        end
        S_TX: begin
          if (tx_left == '0) begin
            st   <= S_RX;
            bidx <= '0;
          end else if (txf_empty) begin
            tx_underrun <= 1'b1;
            if (bidx != '0) begin
              smp_out     <= acc;
              smp_out_vld <= 1'b1;
            end
            st   <= S_RX;
            bidx <= '0;
            acc  <= '0;
          end else begin
            tx_left <= tx_left - 1'b1;
            if (tx_last) begin
              smp_out     <= placed;
              smp_out_vld <= 1'b1;
              acc         <= '0;
              bidx        <= '0;
            end else begin
              acc  <= placed;
              bidx <= bidx + 1'b1;
            end
          end
        end
        S_RX: begin
          if (rx_left == '0) begin
            st <= S_IDLE;
          end else if (rxf_full) begin
            rx_overrun <= 1'b1;
            st         <= S_IDLE;
          end else begin
            rx_left <= rx_left - 1'b1;
            shr     <= (bidx == '0) ? (smp_in >> 8) : (shr >> 8);
            bidx    <= (bidx == bps_q - 1'b1) ? '0 : bidx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req) && ($past(cfg_fmt) == 3'(FMT_SEL)) && $past(cfg_enable)); // R1
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> !txf_empty); // R3
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> cfg_enable && cfg_tx_en && cfg_tx_drive); // R4
  AST_URUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && tx_left != '0 && txf_empty) |=> tx_underrun); // R5
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> !rxf_full); // R7
  AST_ORUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && rx_left != '0 && rxf_full) |=> rx_overrun); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(txf_pop || rxf_push || smp_in_take)); // R8
  AST_VLD_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_out_vld |-> $past(busy)); // R3
endmodule

// File: tb/test_i2s_sample_packer.sv
`timescale 1ns/1ps
module test_i2s_sample_packer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  cfg_fmt = 3'd3;
  logic [6:0]  cfg_width_m1 = 7'd31;
  logic        cfg_enable = 1'b1, cfg_tx_en = 1'b1, cfg_tx_drive = 1'b1, cfg_rx_en = 1'b1;
  logic        req = 1'b0;
  logic [7:0]  req_tx_cnt = '0, req_rx_cnt = '0;
  logic        txf_empty, txf_pop, rxf_full, rxf_push, smp_out_vld, smp_in_take;
  logic        busy, tx_underrun, rx_overrun;
  logic [7:0]  txf_data, rxf_data;
  logic [31:0] smp_out, smp_in;

  logic [7:0]  txq [0:255];
  logic [7:0]  rxq [0:255];
  logic [31:0] cin [0:15];
  logic [31:0] sout [0:255];
  int tx_wr = 0, tx_rd = 0, rx_cnt = 0, rx_base = 0, rx_cap = 64, cin_idx = 0, sout_n = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign txf_empty = (tx_rd == tx_wr);
  assign txf_data  = txq[tx_rd[7:0]];
  assign rxf_full  = (rx_cnt - rx_base) >= rx_cap;
  assign smp_in    = cin[cin_idx[3:0]];

  always @(posedge clk) begin
    if (txf_pop) tx_rd <= tx_rd + 1;
    if (rxf_push) begin
      rxq[rx_cnt[7:0]] <= rxf_data;
      rx_cnt <= rx_cnt + 1;
    end
    if (smp_in_take) cin_idx <= cin_idx + 1;
    if (smp_out_vld) begin
      sout[sout_n[7:0]] <= smp_out;
      sout_n <= sout_n + 1;
    end
  end

  i2s_sample_packer i_i2s_sample_packer (
    .clk, .rst_n, .cfg_fmt, .cfg_width_m1, .cfg_enable, .cfg_tx_en, .cfg_tx_drive,
    .cfg_rx_en, .req, .req_tx_cnt, .req_rx_cnt, .txf_empty, .txf_data, .txf_pop,
    .rxf_full, .rxf_push, .rxf_data, .smp_out, .smp_out_vld, .smp_in, .smp_in_take,
    .busy, .tx_underrun, .rx_overrun);

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    txq[tx_wr[7:0]] = b;
    tx_wr++;
  endtask

  task automatic run(input int ntx, input int nrx, output int cyc);
    @(negedge clk);
    req_tx_cnt = ntx[7:0];
    req_rx_cnt = nrx[7:0];
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 busy", 32'(busy), 0);
    check("R10 flags", {30'd0, tx_underrun, rx_overrun}, 0);
    check("R10 outputs", {29'd0, smp_out_vld, txf_pop, rxf_push}, 0);
  endtask

  task automatic t_tx32;
    int c, s0;
    cfg_width_m1 = 7'd31;
    for (int k = 1; k <= 8; k++) push_tx(8'(k * 17));
    s0 = sout_n;
    run(2, 0, c);
    check("R3 count", 32'(sout_n - s0), 2);
    check("R3 sample0", sout[s0[7:0]], 32'h44332211);
    check("R3 sample1", sout[8'(s0 + 1)], 32'h88776655);
    check("R8 busy cycles", 32'(c), 10);
    check("R5 no underrun exact", 32'(tx_underrun), 0);
  endtask

  task automatic t_tx16_24;
    int c, s0;
    cfg_width_m1 = 7'd15;
    push_tx(8'ha1); push_tx(8'hb2); push_tx(8'hc3);
    push_tx(8'hd4); push_tx(8'he5); push_tx(8'hf6);
    s0 = sout_n;
    run(3, 0, c);
    check("R2 16-bit s0", sout[s0[7:0]], 32'h0000b2a1);
    check("R2 16-bit s2", sout[8'(s0 + 2)], 32'h0000f6e5);
    cfg_width_m1 = 7'd23;
    for (int k = 1; k <= 6; k++) push_tx(8'(k));
    s0 = sout_n;
    run(2, 0, c);
    check("R2 24-bit s0", sout[s0[7:0]], 32'h00030201);
    check("R2 24-bit s1", sout[8'(s0 + 1)], 32'h00060504);
    cfg_width_m1 = 7'd127;
    push_tx(8'h0d); push_tx(8'h0c); push_tx(8'h0b); push_tx(8'h0a);
    s0 = sout_n;
    run(1, 0, c);
    check("R2 capped width", sout[s0[7:0]], 32'h0a0b0c0d);
    check("R2 capped cycles", 32'(c), 6);
  endtask

  task automatic t_underrun;
    int c, s0;
    cfg_width_m1 = 7'd15;
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    s0 = sout_n;
    run(2, 0, c);
    check("R5 underrun set", 32'(tx_underrun), 1);
    check("R5 full sample", sout[s0[7:0]], 32'h00000201);
    check("R5 partial sample", sout[8'(s0 + 1)], 32'h00000003);
    check("R5 cycles", 32'(c), 5);
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33); push_tx(8'h44);
    run(2, 0, c);
    check("R9 underrun cleared by new request", 32'(tx_underrun), 0);
  endtask

  task automatic t_rx;
    int c, t0, b0;
    cfg_width_m1 = 7'd31;
    rx_base = rx_cnt; rx_cap = 64;
    cin[cin_idx[3:0]] = 32'hddccbbaa;
    cin[4'(cin_idx + 1)] = 32'h44332211;
    t0 = cin_idx; b0 = rx_cnt;
    run(0, 2, c);
    check("R6 bytes pushed", 32'(rx_cnt - b0), 8);
    check("R6 byte order lo", {rxq[8'(b0+3)], rxq[8'(b0+2)], rxq[8'(b0+1)], rxq[b0[7:0]]}, 32'hddccbbaa);
    check("R6 byte order hi", {rxq[8'(b0+7)], rxq[8'(b0+6)], rxq[8'(b0+5)], rxq[8'(b0+4)]}, 32'h44332211);
    check("R6 samples taken", 32'(cin_idx - t0), 2);
    check("R8 rx cycles", 32'(c), 10);
    check("R7 no overrun", 32'(rx_overrun), 0);
  endtask

  task automatic t_overrun;
    int c, b0;
    cfg_width_m1 = 7'd31;
    rx_base = rx_cnt; rx_cap = 5; b0 = rx_cnt;
    run(0, 2, c);
    check("R7 overrun set", 32'(rx_overrun), 1);
    check("R7 bytes stop at full", 32'(rx_cnt - b0), 5);
    cfg_fmt = 3'd1;
    rx_base = rx_cnt; rx_cap = 64; b0 = rx_cnt;
    run(0, 2, c);
    check("R1 wrong format no busy", 32'(c), 0);
    check("R1 wrong format no push", 32'(rx_cnt - b0), 0);
    check("R9 overrun held", 32'(rx_overrun), 1);
    cfg_fmt = 3'd3; cfg_enable = 1'b0;
    run(0, 2, c);
    check("R1 disabled no push", 32'(rx_cnt - b0), 0);
    cfg_enable = 1'b1;
    rx_base = rx_cnt; rx_cap = 8;
    run(0, 2, c);
    check("R7 exact fill no overrun", 32'(rx_overrun), 0);
    check("R7 exact fill bytes", 32'(rx_cnt - b0), 8);
  endtask

  task automatic t_tx_gate;
    int c, r0, s0, b0;
    cfg_width_m1 = 7'd7;
    rx_base = rx_cnt; rx_cap = 64;
    push_tx(8'h5a); push_tx(8'ha5);
    cfg_tx_drive = 1'b0;
    r0 = tx_rd; b0 = rx_cnt; s0 = sout_n;
    run(2, 1, c);
    check("R4 no pop without drive", 32'(tx_rd - r0), 0);
    check("R4 no sample", 32'(sout_n - s0), 0);
    check("R4 no underrun", 32'(tx_underrun), 0);
    check("R6 rx still runs", 32'(rx_cnt - b0), 1);
    cfg_tx_drive = 1'b1; cfg_tx_en = 1'b0;
    run(2, 0, c);
    check("R4 no pop without tx enable", 32'(tx_rd - r0), 0);
    cfg_tx_en = 1'b1;
    run(2, 0, c);
    check("R2 8-bit s0", sout[s0[7:0]], 32'h0000005a);
    check("R2 8-bit s1", sout[8'(s0 + 1)], 32'h000000a5);
  endtask

  task automatic t_busy_ignore;
    int c, s0, r0;
    cfg_width_m1 = 7'd31;
    for (int k = 0; k < 8; k++) push_tx(8'(8'h30 + k));
    s0 = sout_n; r0 = tx_rd;
    @(negedge clk);
    req_tx_cnt = 8'd1; req_rx_cnt = 8'd0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 req ignored while busy", 32'(tx_rd - r0), 4);
    check("R8 one sample only", 32'(sout_n - s0), 1);
    run(1, 0, c);
    check("R3 drained sample", sout[8'(s0 + 1)], 32'h37363534);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx32();
    t_tx16_24();
    t_underrun();
    t_rx();
    t_overrun();
    t_tx_gate();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule